// File: doc/BRIEF.md
# Majority-Block Load Coalescer

This unit takes one warp memory access: one address for each of the lanes, a mask of the active lanes, a code for the access size and a load/store flag. It works out which aligned memory block each active lane's address falls in. The block size is set by the size code, and the block is identified by the address bits above the block offset. In plain mode it issues the smallest set of block requests that covers every active lane. Each request carries the block address and the mask of lanes that block serves. Requests go out one per cycle over a valid/ready handshake.

In herding mode, which applies only to loads, the unit counts how many active lanes fall in each candidate block. It keeps only the block with the highest count and issues exactly one request for it, marked as serving every active lane. The per-lane address vector that goes out with that request has its upper, block-identifying bits replaced by the winning block's bits for every active lane outside the winner. The lane keeps its own offset bits, so it reads a nearby word of the popular block. Lanes already inside the winner keep their true addresses.

A new warp is accepted only when the previous one has finished. A warp with an empty active mask is accepted and produces no request.

Top module: `coalescer_herd`

## Requirements
- R1: The size code selects the block size: code 0 is 32 bytes, code 1 is 64 bytes, and codes 2 and 3 are 128 bytes. A request's block address is the lane address with its low log2(block size) bits cleared.
- R2: `in_ready` is high exactly when no warp is in progress. A warp is taken on a cycle where both `in_valid` and `in_ready` are high. After reset `in_ready` is 1 and `req_valid` is 0.
- R3: In plain mode the unit issues one request for each distinct block among the active lanes, and `req_lanes` holds every active lane in that block. Requests are ordered by the lowest active lane number in each block, and each handshake moves on to the next request.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_block`, `req_lanes` and `req_addr` stay unchanged.
- R5: In herding mode (`in_herd`=1, `in_store`=0) the unit issues exactly one request. Its block is the one holding the most active lanes, and its `req_lanes` equals the full active mask.
- R6: When two blocks tie on the highest count in herding mode, the winner is the block that contains the lowest-numbered active lane.
- R7: In herding mode, `req_addr` gives each active lane outside the winner the winner's block bits combined with the lane's own offset bits. Lanes inside the winner and inactive lanes keep their original addresses. In plain mode, `req_addr` equals the input addresses.
- R8: A store (`in_store`=1) is always coalesced in plain mode, even when `in_herd`=1.
- R9: A warp with an all-zero active mask produces no request, and `in_ready` stays high after it is taken.
- R10: Inactive lanes are never counted, never appear in `req_lanes`, and never decide the herding winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Warp access offered |
| in_ready | output | 1 | Unit idle, able to take a warp |
| in_addr | input | LANES*AW | Per-lane addresses, lane i at bits [i*AW +: AW] |
| in_mask | input | LANES | Active-lane mask, bit i for lane i |
| in_size | input | 2 | Block size code (R1) |
| in_store | input | 1 | 1 for a store access |
| in_herd | input | 1 | Request herding for this access |
| req_valid | output | 1 | Block request valid |
| req_ready | input | 1 | Request accepted by the memory side |
| req_block | output | AW | Block-aligned request address |
| req_lanes | output | LANES | Lanes served by this request |
| req_addr | output | LANES*AW | Per-lane addresses to use, rewritten when herding |

## Verification
In herding mode, the choice of the winning block and the rewriting of every outlying lane's address land in the same output cycle as the single request. The bench provokes this with warps whose lanes are split unevenly or evenly across two blocks, including ties and masks that hide a larger group. It judges the result by comparing the block, the lane mask and all lane addresses against a model computed separately. Request backpressure can also fall on any of these cycles. The bench drives `req_ready` with an irregular pattern, so stalls hit both plain multi-request sequences and herded requests. After every stalled cycle it checks that the request held still.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} cstate_e;

  localparam int unsigned MIN_OFFSET_BITS = 5;

  // Offset width for a size code: 32 B, 64 B, 128 B (code 3 folds onto 128 B).
  function automatic int unsigned offset_bits(input logic [1:0] code);
    int unsigned extra;
    extra = (code == 2'd3) ? 2 : int'(code);
    return MIN_OFFSET_BITS + extra;
  endfunction
endpackage

// File: rtl/cb_match_matrix.sv
module cb_match_matrix #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0]          addr,
  input  logic [AW-1:0]                lo_mask,
  output logic [LANES-1:0][LANES-1:0]  same_blk
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_row
    for (genvar gj = 0; gj < LANES; gj++) begin : g_col
      assign same_blk[gi][gj] =
        ((addr[gi*AW +: AW] ^ addr[gj*AW +: AW]) & ~lo_mask) == '0;
    end
  end
endmodule

// File: rtl/cb_popular_pick.sv
module cb_popular_pick #(
  parameter int LANES = 32,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0][LANES-1:0] same_blk,
  input  logic [LANES-1:0]            act,
  output logic [IW-1:0]               win_idx
);
  logic [CW-1:0] best;
  logic [CW-1:0] cnt;

  // Strict compare while scanning upward keeps the block of the lowest lane on ties.
  always_comb begin
    best    = '0;
    win_idx = '0;
    cnt     = '0;
    for (int i = 0; i < LANES; i++) begin
      cnt = CW'($countones(same_blk[i] & act));
      if (act[i] && (cnt > best)) begin
        best    = cnt;
        win_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cb_lane_rewrite.sv
module cb_lane_rewrite #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    act,
  input  logic [LANES-1:0]    in_win,
  input  logic [AW-1:0]       lo_mask,
  input  logic [AW-1:0]       win_blk,
  input  logic                herd,
  output logic [LANES*AW-1:0] addr_out
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic move;
    assign move = herd && act[gi] && !in_win[gi];
    assign addr_out[gi*AW +: AW] = move
      ? (win_blk | (addr[gi*AW +: AW] & lo_mask))
      : addr[gi*AW +: AW];
  end
endmodule

// File: rtl/coalescer_herd.sv
module coalescer_herd #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*AW-1:0] in_addr,
  input  logic [LANES-1:0]    in_mask,
  input  logic [1:0]          in_size,
  input  logic                in_store,
  input  logic                in_herd,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_block,
  output logic [LANES-1:0]    req_lanes,
  output logic [LANES*AW-1:0] req_addr
);
  import coalesce_pkg::*;

  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

  cstate_e             state_q, state_d;
  logic [LANES*AW-1:0] addr_q, addr_d;
  logic [LANES-1:0]    act_q, act_d;
  logic [LANES-1:0]    pend_q, pend_d;
  logic [1:0]          size_q, size_d;
  logic                herd_q, herd_d;
  logic                load_en;

  logic [AW-1:0]                lo_mask;
  logic [LANES-1:0][LANES-1:0]  same_blk;
  logic [IW-1:0]                lead_idx;
  logic [IW-1:0]                win_idx;
  logic [LANES-1:0]             group;
  logic [AW-1:0]                lead_blk;
  logic [AW-1:0]                win_blk;
  logic                         accept;
  logic                         fire;

  assign lo_mask = (AW'(1) << offset_bits(size_q)) - AW'(1);

  cb_match_matrix #(.LANES(LANES), .AW(AW)) u_match (
    .addr     (addr_q),
    .lo_mask  (lo_mask),
    .same_blk (same_blk)
  );

  cb_popular_pick #(.LANES(LANES)) u_pick (
    .same_blk (same_blk),
    .act      (act_q),
    .win_idx  (win_idx)
  );

  // Lowest pending lane leads the next plain-mode request.
  always_comb begin
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_q[i]) lead_idx = IW'(i);
    end
  end

  assign group    = same_blk[lead_idx] & pend_q;
  assign lead_blk = addr_q[lead_idx*AW +: AW] & ~lo_mask;
  assign win_blk  = addr_q[win_idx*AW +: AW] & ~lo_mask;

  cb_lane_rewrite #(.LANES(LANES), .AW(AW)) u_rewrite (
    .addr     (addr_q),
    .act      (act_q),
    .in_win   (same_blk[win_idx]),
    .lo_mask  (lo_mask),
    .win_blk  (win_blk),
    .herd     (herd_q),
    .addr_out (req_addr)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_BUSY);
  assign req_block = herd_q ? win_blk : lead_blk;
  assign req_lanes = herd_q ? act_q : group;
  assign accept    = in_valid && in_ready;
  assign fire      = req_valid && req_ready;
  assign load_en   = accept || fire;

  // Next state
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    act_d   = act_q;
    pend_d  = pend_q;
    size_d  = size_q;
    herd_d  = herd_q;
    if (accept) begin
      addr_d  = in_addr;
      act_d   = in_mask;
      pend_d  = in_mask;
      size_d  = in_size;
      herd_d  = in_herd && !in_store;
      state_d = (in_mask != '0) ? ST_BUSY : ST_IDLE;
    end else if (fire) begin
      pend_d = pend_q & ~group;
      if (herd_q || ((pend_q & ~group) == '0)) begin
        state_d = ST_IDLE;
        pend_d  = '0;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      act_q   <= '0;
      pend_q  <= '0;
      size_q  <= '0;
      herd_q  <= 1'b0;
    end else if (load_en) begin
      state_q <= state_d;
      addr_q  <= addr_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      size_q  <= size_d;
      herd_q  <= herd_d;
    end
  end
endmodule

// File: rtl/coalescer_herd_chk.sv
module coalescer_herd_chk #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                req_valid,
  input logic                req_ready,
  input logic [AW-1:0]       req_block,
  input logic [LANES-1:0]    req_lanes,
  input logic [LANES*AW-1:0] req_addr,
  input logic [LANES-1:0]    act_q,
  input logic                herd_q
);
  // R2: a request and an open input are never offered together
  a_r2_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !in_ready);

  // R3: every request serves at least one lane
  a_r3_lanes_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_lanes != '0));

  // R10: only active lanes are served
  a_r10_lanes_active: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_lanes & ~act_q) == '0));

  // R4: a stalled request holds still
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_block) &&
                                   $stable(req_lanes) && $stable(req_addr)));

  // R5: a herded warp ends after its single request
  a_r5_herd_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && herd_q) |=> !req_valid);

  // R1: block address is at least 32-byte aligned
  a_r1_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_block[4:0] == 5'd0));
endmodule

bind coalescer_herd coalescer_herd_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_block (req_block),
  .req_lanes (req_lanes),
  .req_addr  (req_addr),
  .act_q     (act_q),
  .herd_q    (herd_q)
);

// File: tb/coalescer_herd_bench.sv
`timescale 1ns/1ps
module coalescer_herd_bench;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic                in_ready;
  logic [LANES*AW-1:0] in_addr;
  logic [LANES-1:0]    in_mask;
  logic [1:0]          in_size;
  logic                in_store;
  logic                in_herd;
  logic                req_valid;
  logic                req_ready;
  logic [AW-1:0]       req_block;
  logic [LANES-1:0]    req_lanes;
  logic [LANES*AW-1:0] req_addr;

  coalescer_herd #(.LANES(LANES), .AW(AW)) u_coalescer_herd (
    .clk, .rst_n, .in_valid, .in_ready, .in_addr, .in_mask, .in_size,
    .in_store, .in_herd, .req_valid, .req_ready, .req_block, .req_lanes,
    .req_addr
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [AW-1:0]       blk;
    logic [LANES-1:0]    lanes;
    logic [LANES*AW-1:0] oaddr;
    string               tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [AW-1:0] ta [LANES];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [LANES*AW-1:0] got, input logic [LANES*AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] lo_of(input logic [1:0] sz);
    int sh;
    sh = 5 + ((sz == 2'd3) ? 2 : int'(sz));
    return (AW'(1) << sh) - AW'(1);
  endfunction

  // Driver: builds expectations from the requirements, then offers the warp.
  task automatic send(input logic [LANES-1:0] m, input logic [1:0] sz,
                      input logic st, input logic hd, input string tag);
    logic [AW-1:0] lo;
    logic [LANES*AW-1:0] flat;
    logic [LANES-1:0] done_l;
    exp_t e;
    lo = lo_of(sz);
    for (int i = 0; i < LANES; i++) flat[i*AW +: AW] = ta[i];
    if (m != '0) begin
      if (hd && !st) begin
        int best; int wi;
        best = 0; wi = 0;
        for (int i = 0; i < LANES; i++) begin
          int c; c = 0;
          for (int j = 0; j < LANES; j++)
            if (m[j] && ((ta[j] & ~lo) == (ta[i] & ~lo))) c++;
          if (m[i] && c > best) begin best = c; wi = i; end
        end
        e.blk = ta[wi] & ~lo;
        e.lanes = m;
        for (int i = 0; i < LANES; i++)
          e.oaddr[i*AW +: AW] = (m[i] && ((ta[i] & ~lo) != e.blk))
                                ? (e.blk | (ta[i] & lo)) : ta[i];
        e.tag = tag;
        q.push_back(e);
      end else begin
        done_l = '0;
        for (int i = 0; i < LANES; i++) begin
          if (m[i] && !done_l[i]) begin
            e.blk = ta[i] & ~lo;
            e.lanes = '0;
            for (int j = 0; j < LANES; j++)
              if (m[j] && ((ta[j] & ~lo) == e.blk)) e.lanes[j] = 1'b1;
            done_l |= e.lanes;
            e.oaddr = flat;
            e.tag = tag;
            q.push_back(e);
          end
        end
      end
    end
    @(negedge clk);
    in_addr = flat; in_mask = m; in_size = sz; in_store = st; in_herd = hd;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || !in_ready) @(negedge clk);
  endtask

  // Monitor: irregular backpressure, scoreboard compare, hold check (R4).
  int rcnt = 0;
  bit stalled = 0;
  logic [AW-1:0] s_blk;
  logic [LANES-1:0] s_lanes;
  logic [LANES*AW-1:0] s_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      rcnt++;
      req_ready <= ((rcnt % 3) != 1);
      #1;
      if (stalled) begin
        chk(req_valid && req_block == s_blk && req_lanes == s_lanes && req_addr == s_addr,
            "R4", "hold", {req_block, req_lanes}, {s_blk, s_lanes});
      end
      stalled = req_valid && !req_ready;
      s_blk = req_block; s_lanes = req_lanes; s_addr = req_addr;
      if (req_valid && req_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3", "unexpected request", req_block, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(req_block == e.blk, e.tag, "block", req_block, e.blk);
          chk(req_lanes == e.lanes, e.tag, "lanes", req_lanes, e.lanes);
          chk(req_addr == e.oaddr, e.tag, "addr", req_addr, e.oaddr);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_mask = '0;
    in_size = '0; in_store = 1'b0; in_herd = 1'b0; req_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1 && req_valid == 1'b0, "R2", "reset state",
        {in_ready, req_valid}, 2'b10);
    rst_n = 1'b1;

    // R1/R3: consecutive words, 128 B blocks -> one request
    for (int i = 0; i < LANES; i++) ta[i] = 32'h1000 + 4 * i;
    send('1, 2'd2, 1'b0, 1'b0, "R1_r3_128B");
    // R1: same addresses, 32 B blocks -> four requests of 8 lanes
    send('1, 2'd0, 1'b0, 1'b0, "R1_32B");
    // R1: size code 3 behaves as 128 B
    send('1, 2'd3, 1'b0, 1'b0, "R1_code3");
    drain();

    // R3: scattered, 64 B blocks, partial mask
    for (int i = 0; i < LANES; i++) ta[i] = 32'h400 + 32'h40 * (i % 3) + i;
    send(32'hF0F0_F0F0, 2'd1, 1'b0, 1'b0, "R3_scatter");
    drain();

    // R5/R7: herding, 12 lanes in 0x2000, 20 lanes in 0x3000
    for (int i = 0; i < LANES; i++) ta[i] = ((i < 12) ? 32'h2000 : 32'h3000) + 4 * i;
    send('1, 2'd2, 1'b0, 1'b1, "R5_r7_herd");
    drain();
    // R8: same warp as a store stays plain
    send('1, 2'd2, 1'b1, 1'b1, "R8_store");
    drain();

    // R6: tie 16/16, lane 0 in 0x6000
    for (int i = 0; i < LANES; i++) ta[i] = ((i % 2 == 0) ? 32'h6000 : 32'h5000) + 4 * i;
    send('1, 2'd2, 1'b0, 1'b1, "R6_tie_lane0");
    drain();
    // R6: lane 0 inactive, 15 vs 16 -> 0x5000 wins by count
    send(32'hFFFF_FFFE, 2'd2, 1'b0, 1'b1, "R6_count");
    drain();
    // R6: tie 15/15 without lanes 0 and 31 -> block of lane 1 (0x5000)
    send(32'h7FFF_FFFE, 2'd2, 1'b0, 1'b1, "R6_tie_lane1");
    drain();

    // R10: 22 lanes in 0x8000 but only 6 of them active
    for (int i = 0; i < LANES; i++) ta[i] = ((i < 10) ? 32'h7000 : 32'h8000) + 4 * i;
    send(32'h0000_FFFF, 2'd2, 1'b0, 1'b1, "R10_inactive");
    drain();

    // R9: empty mask
    send('0, 2'd2, 1'b0, 1'b1, "R9_empty");
    chk(in_ready == 1'b1 && req_valid == 1'b0 && q.size() == 0, "R9", "empty mask",
        {in_ready, req_valid}, 2'b10);
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R9", "no request later", req_valid, 1'b0);

    // R2/R3: back-to-back warps with mixed modes
    for (int i = 0; i < LANES; i++) ta[i] = 32'h9000 + 32'h20 * (i % 4) + (i % 8);
    send(32'h0F0F_00FF, 2'd0, 1'b0, 1'b0, "R2_b2b_plain");
    send(32'h0F0F_00FF, 2'd0, 1'b0, 1'b1, "R2_b2b_herd");
    drain();
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3", "scoreboard empty", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, pending=%0d", q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule